// File: doc/BRIEF.md
# Cell-Granular Transmit Octet Buffer

This block sits between an upstream cell source and a line framer. The source hands over ATM cell data one octet at a time. It writes an octet on any clock where its active-low write enable is low, and it may pause between octets for as long as it likes. The buffer groups the octets into 53-byte cells. The framer side sees a cell only when all 53 of its bytes have arrived.

Fill is counted in whole cells. When the count of complete stored cells reaches the full threshold, an active-low full flag goes low. Any octet offered while that flag is low is dropped, which gives the source a safe window to stop after it sees the flag. One cell slot beyond the threshold is reserved for the cell being assembled, so storage can never be overrun. The framer drains cells byte by byte over a valid/ready handshake. Markers flag the first and last byte of each cell.

Top module: `cell_tx_fifo`

## Requirements
- R1: An octet on `txData` is stored only on a rising clock edge where `txEnN` is 0. With `txEnN` at 1 nothing is stored, however long the idle period or whatever the data.
- R2: Each cell is read out as exactly 53 bytes. `rdSoc` is 1 on byte index 0 only and `rdEoc` is 1 on byte index 52 only. After a cell's last byte is accepted, the next byte offered (if any) carries `rdSoc`.
- R3: `rdValid` is 1 exactly when at least one complete 53-byte cell is stored. A cell with 52 or fewer bytes written is never offered.
- R4: `fullN` is 0 exactly while 7 complete cells are stored, and 1 otherwise.
- R5: Octets offered with `txEnN` at 0 while `fullN` is 0 are discarded. They alter neither the stored cells nor the position of the next stored octet.
- R6: Once a cell is drained from a full buffer, `fullN` returns to 1. The next enabled octet is stored as byte 0 of a new cell.
- R7: Cells are delivered in the order they were completed, and the bytes of each cell in the order they were written.
- R8: A byte is removed only on a clock edge where `rdValid` and `rdReady` are both 1. While `rdValid` is 1 and `rdReady` is 0, `rdData`, `rdSoc` and `rdEoc` hold.
- R9: Synchronous active-high `rst` empties the buffer. A partly written cell is discarded, `rdValid` is 0, `fullN` is 1, and the next stored octet is byte 0 of a new cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txEnN | input | 1 | Write enable, active low |
| txData | input | 8 | Octet to store |
| fullN | output | 1 | Low while the cell threshold is reached |
| rdValid | output | 1 | A complete cell byte is on offer |
| rdReady | input | 1 | Framer accepts the offered byte |
| rdData | output | 8 | Offered byte |
| rdSoc | output | 1 | Offered byte is the first of its cell |
| rdEoc | output | 1 | Offered byte is the last of its cell |

## Verification
The assertions assume the framer keeps `rdReady` a plain level, sampled at the edge. They do not assume the writer obeys `fullN`: the drop behaviour is checked against a writer that keeps its enable low after the flag falls. Stimulus changes `txEnN`, `txData` and `rdReady` only on the falling edge, so each rising edge sees settled inputs. Scenarios cover gapped writing with changing idle data, filling to the threshold and overdriving it, draining with stalls, and a reset in the middle of a partial cell.

// File: rtl/cell_tx_fifo_pkg.sv
package cell_tx_fifo_pkg;
  localparam int unsigned DefDataW     = 8;
  localparam int unsigned DefCellBytes = 53;
  localparam int unsigned DefSlots     = 8;
  localparam int unsigned DefFullCells = 7;

  // Strobes from the control unit to the storage array.
  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
  } fifoStrobes_t;
endpackage

// File: rtl/cell_tx_fifo_ctrl.sv
module cell_tx_fifo_ctrl
  import cell_tx_fifo_pkg::*;
#(
  parameter int unsigned CELL_BYTES = DefCellBytes,
  parameter int unsigned SLOTS      = DefSlots,
  parameter int unsigned FULL_CELLS = DefFullCells,
  localparam int unsigned DEPTH     = SLOTS * CELL_BYTES,
  localparam int unsigned ADDR_W    = $clog2(DEPTH),
  localparam int unsigned BYTE_W    = $clog2(CELL_BYTES),
  localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txEnN,
  input  logic              rdReady,
  output logic              fullN,
  output logic              rdValid,
  output logic              rdSoc,
  output logic              rdEoc,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  logic [BYTE_W-1:0] wrByte, rdByte;
  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [SLOT_W-1:0] wrSlotNext, rdSlotNext;
  logic [CNT_W-1:0]  completeCells;
  logic              wrFire, rdFire, wrCellDone, rdCellDone;

  assign fullN   = (completeCells < CNT_W'(FULL_CELLS));
  assign rdValid = (completeCells != '0);

  assign wrFire     = !txEnN && fullN;
  assign rdFire     = rdValid && rdReady;
  assign wrCellDone = wrFire && (wrByte == BYTE_W'(CELL_BYTES - 1));
  assign rdCellDone = rdFire && (rdByte == BYTE_W'(CELL_BYTES - 1));

  assign rdSoc = rdValid && (rdByte == '0);
  assign rdEoc = rdValid && (rdByte == BYTE_W'(CELL_BYTES - 1));

  assign strobes.wrStrobe = wrFire;
  assign strobes.rdStrobe = rdFire;

  assign wrAddr = ADDR_W'(wrSlot) * ADDR_W'(CELL_BYTES) + ADDR_W'(wrByte);
  assign rdAddr = ADDR_W'(rdSlot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rdByte);

  // Slot wrap: natural rollover for a power-of-two slot count, compare otherwise.
  generate
    if ((SLOTS & (SLOTS - 1)) == 0) begin : g_wrapPow2
      assign wrSlotNext = wrSlot + 1'b1;
      assign rdSlotNext = rdSlot + 1'b1;
    end else begin : g_wrapCmp
      assign wrSlotNext = (wrSlot == SLOT_W'(SLOTS - 1)) ? '0 : wrSlot + 1'b1;
      assign rdSlotNext = (rdSlot == SLOT_W'(SLOTS - 1)) ? '0 : rdSlot + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wrByte <= '0;
      wrSlot <= '0;
    end else if (wrFire) begin
      if (wrCellDone) begin
        wrByte <= '0;
        wrSlot <= wrSlotNext;
      end else begin
        wrByte <= wrByte + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdByte <= '0;
      rdSlot <= '0;
    end else if (rdFire) begin
      if (rdCellDone) begin
        rdByte <= '0;
        rdSlot <= rdSlotNext;
      end else begin
        rdByte <= rdByte + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      completeCells <= '0;
    end else if (wrCellDone && !rdCellDone) begin
      completeCells <= completeCells + 1'b1;
    end else if (rdCellDone && !wrCellDone) begin
      completeCells <= completeCells - 1'b1;
    end
  end

  // Disabled cycles leave the write cursor untouched.
  assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    txEnN |=> ($stable(wrByte) && $stable(wrSlot)));

  // Enabled octets while full do not move the write cursor.
  assert_drop_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (!fullN && !txEnN) |=> ($stable(wrByte) && $stable(wrSlot)));

  // Stored cell count never passes the threshold.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    completeCells <= CNT_W'(FULL_CELLS));

  // Completing the threshold cell drops the full flag.
  assert_full_on_last_cell_R4: assert property (@(posedge clk) disable iff (rst)
    (wrCellDone && !rdCellDone && completeCells == CNT_W'(FULL_CELLS - 1)) |=> !fullN);

  // After the last byte of a cell, the next offered byte opens a cell.
  assert_soc_after_eoc_R2: assert property (@(posedge clk) disable iff (rst)
    (rdFire && rdEoc) |=> (!rdValid || rdSoc));

endmodule

// File: rtl/cell_tx_fifo_datapath.sv
module cell_tx_fifo_datapath
  import cell_tx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = DefDataW,
  parameter int unsigned CELL_BYTES = DefCellBytes,
  parameter int unsigned SLOTS      = DefSlots,
  localparam int unsigned DEPTH     = SLOTS * CELL_BYTES,
  localparam int unsigned ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] cellMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrStrobe) begin
      cellMem[wrAddr] <= wrData;
    end
  end

  assign rdData = cellMem[rdAddr];

  // Writing and reading one address in the same cycle would tear a cell.
  always_comb begin
    if (strobes.wrStrobe && strobes.rdStrobe) begin
      assert_no_same_addr_R3: assert (wrAddr != rdAddr);
    end
  end

endmodule

// File: rtl/cell_tx_fifo.sv
module cell_tx_fifo
  import cell_tx_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = DefDataW,
  parameter int unsigned CELL_BYTES = DefCellBytes,
  parameter int unsigned SLOTS      = DefSlots,
  parameter int unsigned FULL_CELLS = DefFullCells,
  localparam int unsigned DEPTH     = SLOTS * CELL_BYTES,
  localparam int unsigned ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txEnN,
  input  logic [DATA_W-1:0] txData,
  output logic              fullN,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSoc,
  output logic              rdEoc
);

  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  cell_tx_fifo_ctrl #(
    .CELL_BYTES(CELL_BYTES),
    .SLOTS     (SLOTS),
    .FULL_CELLS(FULL_CELLS)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .txEnN  (txEnN),
    .rdReady(rdReady),
    .fullN  (fullN),
    .rdValid(rdValid),
    .rdSoc  (rdSoc),
    .rdEoc  (rdEoc),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr)
  );

  cell_tx_fifo_datapath #(
    .DATA_W    (DATA_W),
    .CELL_BYTES(CELL_BYTES),
    .SLOTS     (SLOTS)
  ) u_datapath (
    .clk    (clk),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .wrData (txData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  // A stalled offer keeps its byte and markers.
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData) && $stable(rdSoc) && $stable(rdEoc)));

endmodule

// File: tb/cell_tx_fifo_tb.sv
module cell_tx_fifo_tb;
  localparam int CellB = 53;
  localparam int FullC = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txEnN = 1'b1;
  logic [7:0] txData = 8'h00;
  logic       fullN, rdValid, rdSoc, rdEoc;
  logic       rdReady = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  int mCells = 0;
  int mByte  = 0;
  int rdPos  = 0;
  logic [7:0] expQ[$];

  always #5 clk = ~clk;

  cell_tx_fifo u_dut (
    .clk(clk), .rst(rst), .txEnN(txEnN), .txData(txData), .fullN(fullN),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData), .rdSoc(rdSoc), .rdEoc(rdEoc)
  );

  function automatic logic [7:0] patt(int c, int i);
    return 8'((c * 37) + (i * 5) + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; txEnN = 1'b1; rdReady = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mCells = 0; mByte = 0; rdPos = 0;
    expQ.delete();
  endtask

  task automatic wrByte(logic [7:0] d);
    @(negedge clk);
    check(fullN == (mCells < FullC), "R4 fullN", int'(fullN), int'(mCells < FullC));
    txEnN = 1'b0; txData = d;
    @(posedge clk);
    if (mCells < FullC) begin
      expQ.push_back(d);
      mByte++;
      if (mByte == CellB) begin mByte = 0; mCells++; end
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    txEnN = 1'b1;
    for (int k = 0; k < n; k++) begin
      txData = 8'(k * 13 + 7);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic writeCell(int c, int gap);
    for (int i = 0; i < CellB; i++) begin
      wrByte(patt(c, i));
      if (gap != 0 && (i % gap) == 0) idle(2);
    end
    idle(1);
  endtask

  task automatic readCells(int n, bit stall, string req);
    int done = 0;
    int cyc = 0;
    logic [7:0] held;
    bit wasStall = 0;
    while (done < n) begin
      @(negedge clk);
      cyc++;
      check(rdValid == 1'b1, "R3 rdValid", int'(rdValid), 1);
      check(rdData == expQ[0], req, int'(rdData), int'(expQ[0]));
      check(rdSoc == (rdPos == 0), "R2 rdSoc", int'(rdSoc), int'(rdPos == 0));
      check(rdEoc == (rdPos == CellB - 1), "R2 rdEoc", int'(rdEoc), int'(rdPos == CellB - 1));
      if (wasStall) check(rdData == held, "R8 hold", int'(rdData), int'(held));
      if (stall && (cyc % 3 == 0)) begin
        rdReady = 1'b0; held = rdData; wasStall = 1;
        @(posedge clk);
      end else begin
        rdReady = 1'b1; wasStall = 0;
        @(posedge clk);
        void'(expQ.pop_front());
        rdPos++;
        if (rdPos == CellB) begin rdPos = 0; mCells--; done++; end
      end
    end
    @(negedge clk);
    rdReady = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(rdValid == 1'b0, "R9 rdValid after reset", int'(rdValid), 0);
    check(fullN == 1'b1, "R9 fullN after reset", int'(fullN), 1);
  endtask

  task automatic testGapped();
    idle(60);
    check(rdValid == 1'b0, "R1 no write while disabled", int'(rdValid), 0);
    for (int i = 0; i < CellB - 1; i++) begin
      wrByte(patt(1, i));
      if (i % 4 == 0) idle(3);
    end
    idle(2);
    check(rdValid == 1'b0, "R3 partial cell hidden", int'(rdValid), 0);
    wrByte(patt(1, CellB - 1));
    idle(1);
    check(rdValid == 1'b1, "R3 complete cell offered", int'(rdValid), 1);
    writeCell(2, 0);
    readCells(2, 1'b0, "R1 data");
    check(rdValid == 1'b0, "R3 empty after drain", int'(rdValid), 0);
  endtask

  task automatic testFill();
    for (int c = 0; c < FullC; c++) writeCell(10 + c, 0);
    check(fullN == 1'b0, "R4 full at threshold", int'(fullN), 0);
    for (int k = 0; k < 5; k++) wrByte(8'hEE);
    idle(1);
    check(fullN == 1'b0, "R5 still full after drops", int'(fullN), 0);
    readCells(1, 1'b1, "R5 data");
    check(fullN == 1'b1, "R6 full released", int'(fullN), 1);
    writeCell(40, 5);
    check(fullN == 1'b0, "R4 full again", int'(fullN), 0);
    readCells(FullC, 1'b1, "R7 data");
    check(expQ.size() == 0, "R6 scoreboard drained", expQ.size(), 0);
    check(rdValid == 1'b0, "R3 empty after fill drain", int'(rdValid), 0);
    check(fullN == 1'b1, "R4 not full when empty", int'(fullN), 1);
  endtask

  task automatic testMidReset();
    writeCell(60, 0);
    writeCell(61, 0);
    for (int i = 0; i < 20; i++) wrByte(patt(62, i));
    doReset();
    check(rdValid == 1'b0, "R9 flushed", int'(rdValid), 0);
    check(fullN == 1'b1, "R9 fullN", int'(fullN), 1);
    writeCell(63, 0);
    readCells(1, 1'b0, "R9 data");
    check(rdValid == 1'b0, "R9 single cell", int'(rdValid), 0);
  endtask

  initial begin
    testReset();
    testGapped();
    testFill();
    testMidReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule